// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and a calendar in packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A clock-enable at the nominal 32.768 kHz rate drives an internal divider, and the divider produces one count per second. Each count ripples through the fields, with the correct carries at every minute, hour, midnight, month end and year end.

The hours byte holds either a 24-hour value or a 12-hour value with an AM/PM flag. The date follows the length of each month, and February has 29 days in leap years. A host loads any field through a shared data bus and a per-field write strobe. A halt flag in the seconds byte freezes all counting. Writing the seconds byte restarts the sub-second divider, so the next count comes one full second after the write. The outputs are the seven packed register bytes. Unused bits in them always read 0.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the bytes read seconds 0x00 (halt bit 7 clear), minutes 0x00, hours 0x00 (24-hour), day 0x01, date 0x01, month 0x01, year 0x00.
- R2: With halt clear, the seconds value advances by one each time DIV_COUNT (default 32768) cycles with tickEn high have passed since the last seconds write or the last advance. A write with wrEn[0] restarts this count from zero. Cycles with tickEn low are not counted.
- R3: While seconds bit 7 is 1, no field advances and the divider holds. Seconds bit 7 is written together with the seconds value.
- R4: Seconds and minutes count in BCD from 00 to 59. Seconds 59 wraps to 00 and advances the minutes. Minutes 59 wraps together with seconds 59 and advances the hours.
- R5: When hours bit 6 is 0 (24-hour mode), bits 5:0 count in BCD from 00 to 23. Hour 23 rolls to 00 at the minute carry, and that is midnight.
- R6: When hours bit 6 is 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 run from 01 to 12. Hour 11 goes to 12 and inverts bit 5. Hour 12 goes to 01 and keeps bit 5. Midnight is the step from 11 PM to 12 AM.
- R7: The day of week counts 1 to 7, wraps 7 to 1, and advances only at midnight, in the same cycle as the date.
- R8: At midnight the date wraps to 01 and advances the month after 30 for months 04, 06, 09 and 11, and after 31 for the other months except 02.
- R9: In February the date wraps after 29 when the BCD year is divisible by 4 (year 00 included) and after 28 otherwise.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R11: Write strobes wrEn[0..6] select seconds, minutes, hours, day, date, month and year. Bits that a field does not use are dropped on write and read as 0: bit 7 of minutes and hours, bits 7:3 of day, 7:6 of date, 7:5 of month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 32.768 kHz clock-enable pulse |
| wrEn | input | 7 | Per-field write strobes (0 sec .. 6 year) |
| wrData | input | 8 | Write data shared by all fields |
| secByte | output | 8 | Halt flag and BCD seconds |
| minByte | output | 8 | BCD minutes |
| hourByte | output | 8 | Mode, PM or tens-of-twenty flag, BCD hours |
| dayByte | output | 8 | Day of week |
| dateByte | output | 8 | BCD date |
| monthByte | output | 8 | BCD month |
| yearByte | output | 8 | BCD year |

## Verification
The bench loads times close to each boundary and then lets the clock run. Loads at a plain second, at the end of a minute and at midnight in both hour formats separate each carry stage from the one before it. Month ends at 30 and 31, February in a leap year and in a common year, and December of year 99 confirm that the date wrap depends on both the month and the year. Partial seconds, halted periods, gaps in the enable and restarts of the divider check the spacing of the counts. Writes with stray high bits show the field masking.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int FIELD_COUNT = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DAY   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  typedef struct packed {
    logic incSec;
    logic incMin;
    logic incHour;
    logic incDate;
    logic incMonth;
    logic incYear;
  } rtcStrobes_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/bcd_rtc_ctrl.sv
module bcd_rtc_ctrl
  import bcd_rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        halt,
  input  logic        secWrite,
  input  logic        secAtMax,
  input  logic        minAtMax,
  input  logic        dayEnd,
  input  logic        dateAtMax,
  input  logic        monthAtMax,
  output rtcStrobes_t strobes
);

  localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] divCount;
  logic          countEn;
  logic          secTick;

  assign countEn = tickEn && !halt;
  assign secTick = countEn && (divCount == LAST) && !secWrite;

  always_ff @(posedge clk) begin
    if (!rstN || secWrite) divCount <= '0;
    else if (countEn)      divCount <= (divCount == LAST) ? '0 : divCount + 1'b1;
  end

  always_comb begin
    strobes.incSec   = secTick;
    strobes.incMin   = secTick && secAtMax;
    strobes.incHour  = strobes.incMin && minAtMax;
    strobes.incDate  = strobes.incHour && dayEnd;
    strobes.incMonth = strobes.incDate && dateAtMax;
    strobes.incYear  = strobes.incMonth && monthAtMax;
  end

endmodule

// File: rtl/bcd_rtc_datapath.sv
module bcd_rtc_datapath
  import bcd_rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FIELD_COUNT-1:0] wrEn,
  input  logic [7:0]             wrData,
  input  rtcStrobes_t            strobes,
  output logic                   halt,
  output logic                   secAtMax,
  output logic                   minAtMax,
  output logic                   dayEnd,
  output logic                   dateAtMax,
  output logic                   monthAtMax,
  output logic [7:0]             secByte,
  output logic [7:0]             minByte,
  output logic [7:0]             hourByte,
  output logic [7:0]             dayByte,
  output logic [7:0]             dateByte,
  output logic [7:0]             monthByte,
  output logic [7:0]             yearByte
);

  logic [6:0] secVal, minVal, hourVal;
  logic [2:0] dayVal;
  logic [5:0] dateVal;
  logic [4:0] monthVal;
  logic [7:0] yearVal;

  logic       mode12, pmBit;
  logic [7:0] hour12, hour24, hourNext;
  logic       leapYear;
  logic [7:0] lastDate;
  logic       shortMonth;

  assign mode12 = hourVal[6];
  assign pmBit  = hourVal[5];
  assign hour12 = {3'b000, hourVal[4:0]};
  assign hour24 = {2'b00, hourVal[5:0]};

  // Next hour in the current format
  always_comb begin
    if (mode12) begin
      if (hour12 == 8'h11)      hourNext = {1'b0, 1'b1, ~pmBit, 5'h12};
      else if (hour12 == 8'h12) hourNext = {1'b0, 1'b1, pmBit, 5'h01};
      else                      hourNext = {1'b0, 1'b1, pmBit, bcdInc(hour12)[4:0]};
    end else begin
      if (hour24 == 8'h23)      hourNext = 8'h00;
      else                      hourNext = {2'b00, bcdInc(hour24)[5:0]};
    end
  end

  assign dayEnd = mode12 ? (pmBit && hour12 == 8'h11) : (hour24 == 8'h23);

  // BCD year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  always_comb begin
    if (yearVal[4] == 1'b0)
      leapYear = (yearVal[3:0] == 4'd0) || (yearVal[3:0] == 4'd4) || (yearVal[3:0] == 4'd8);
    else
      leapYear = (yearVal[3:0] == 4'd2) || (yearVal[3:0] == 4'd6);
  end

  assign shortMonth = (monthVal == 5'h04) || (monthVal == 5'h06) ||
                      (monthVal == 5'h09) || (monthVal == 5'h11);

  always_comb begin
    if (monthVal == 5'h02) lastDate = leapYear ? 8'h29 : 8'h28;
    else if (shortMonth)   lastDate = 8'h30;
    else                   lastDate = 8'h31;
  end

  assign secAtMax   = (secVal == 7'h59);
  assign minAtMax   = (minVal == 7'h59);
  assign dateAtMax  = ({2'b00, dateVal} == lastDate);
  assign monthAtMax = (monthVal == 5'h12);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halt     <= 1'b0;
      secVal   <= '0;
      minVal   <= '0;
      hourVal  <= '0;
      dayVal   <= 3'd1;
      dateVal  <= 6'h01;
      monthVal <= 5'h01;
      yearVal  <= '0;
    end else begin
      if (wrEn[F_SEC]) begin
        halt   <= wrData[7];
        secVal <= wrData[6:0];
      end else if (strobes.incSec) begin
        secVal <= secAtMax ? 7'h00 : bcdInc({1'b0, secVal})[6:0];
      end

      if (wrEn[F_MIN])         minVal <= wrData[6:0];
      else if (strobes.incMin) minVal <= minAtMax ? 7'h00 : bcdInc({1'b0, minVal})[6:0];

      if (wrEn[F_HOUR])         hourVal <= wrData[6:0];
      else if (strobes.incHour) hourVal <= hourNext[6:0];

      if (wrEn[F_DAY])          dayVal <= wrData[2:0];
      else if (strobes.incDate) dayVal <= (dayVal == 3'd7) ? 3'd1 : dayVal + 3'd1;

      if (wrEn[F_DATE])         dateVal <= wrData[5:0];
      else if (strobes.incDate) dateVal <= dateAtMax ? 6'h01 : bcdInc({2'b00, dateVal})[5:0];

      if (wrEn[F_MONTH])         monthVal <= wrData[4:0];
      else if (strobes.incMonth) monthVal <= monthAtMax ? 5'h01 : bcdInc({3'b000, monthVal})[4:0];

      if (wrEn[F_YEAR])         yearVal <= wrData;
      else if (strobes.incYear) yearVal <= (yearVal == 8'h99) ? 8'h00 : bcdInc(yearVal);
    end
  end

  assign secByte   = {halt, secVal};
  assign minByte   = {1'b0, minVal};
  assign hourByte  = {1'b0, hourVal};
  assign dayByte   = {5'b00000, dayVal};
  assign dateByte  = {2'b00, dateVal};
  assign monthByte = {3'b000, monthVal};
  assign yearByte  = yearVal;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [6:0] wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] secByte,
  output logic [7:0] minByte,
  output logic [7:0] hourByte,
  output logic [7:0] dayByte,
  output logic [7:0] dateByte,
  output logic [7:0] monthByte,
  output logic [7:0] yearByte
);

  rtcStrobes_t strobes;
  logic halt, secAtMax, minAtMax, dayEnd, dateAtMax, monthAtMax;

  bcd_rtc_ctrl #(.DIV_COUNT(DIV_COUNT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .halt       (halt),
    .secWrite   (wrEn[F_SEC]),
    .secAtMax   (secAtMax),
    .minAtMax   (minAtMax),
    .dayEnd     (dayEnd),
    .dateAtMax  (dateAtMax),
    .monthAtMax (monthAtMax),
    .strobes    (strobes)
  );

  bcd_rtc_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .strobes    (strobes),
    .halt       (halt),
    .secAtMax   (secAtMax),
    .minAtMax   (minAtMax),
    .dayEnd     (dayEnd),
    .dateAtMax  (dateAtMax),
    .monthAtMax (monthAtMax),
    .secByte    (secByte),
    .minByte    (minByte),
    .hourByte   (hourByte),
    .dayByte    (dayByte),
    .dateByte   (dateByte),
    .monthByte  (monthByte),
    .yearByte   (yearByte)
  );

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
  parameter int DIV_COUNT = 32768
) (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic [6:0] wrEn,
  input logic [7:0] wrData,
  input logic [7:0] secByte,
  input logic [7:0] minByte,
  input logic [7:0] hourByte,
  input logic [7:0] dayByte,
  input logic [7:0] dateByte,
  input logic [7:0] monthByte,
  input logic [7:0] yearByte
);

  localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] enSeen;
  logic          dueNow;

  assign dueNow = tickEn && !secByte[7] && (enSeen == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || wrEn[0])           enSeen <= '0;
    else if (tickEn && !secByte[7]) enSeen <= (enSeen == LAST) ? '0 : enSeen + 1'b1;
  end

  // R2: seconds stay put until the divider window has elapsed
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn[0] && !dueNow) |=> $stable(secByte));

  // R3: a halted clock with no writes changes nothing
  a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (secByte[7] && wrEn == 7'd0) |=> $stable({secByte, minByte, hourByte, dayByte,
                                              dateByte, monthByte, yearByte}));

  // R7: date advancing on its own moves the day of week too
  a_r7_dow_with_date: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn[3] && !wrEn[4]) |=> ($stable(dateByte) || !$stable(dayByte)));

  // R11: unused bits read zero
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (minByte[7] == 1'b0) && (hourByte[7] == 1'b0) && (dayByte[7:3] == 5'd0) &&
    (dateByte[7:6] == 2'd0) && (monthByte[7:5] == 3'd0));

  // R6: in 12-hour mode, an hour advance never yields hour 00
  a_r6_no_hour_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hourByte[6] && !wrEn[2]) |=> (hourByte[4:0] != 5'h00) || !$changed(hourByte));

  // R4: the minutes never change by counting while seconds are not wrapping from 59
  a_r4_min_carry: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn[1] && secByte[6:0] != 7'h59) |=> $stable(minByte));

  logic unusedData;
  assign unusedData = ^wrData;

endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.DIV_COUNT(DIV_COUNT)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
  .secByte(secByte), .minByte(minByte), .hourByte(hourByte), .dayByte(dayByte),
  .dateByte(dateByte), .monthByte(monthByte), .yearByte(yearByte)
);

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [6:0] wrEn = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secByte, minByte, hourByte, dayByte, dateByte, monthByte, yearByte;

  int total = 0;
  int bad = 0;
  bit summaryDone = 0;

  logic [55:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  bcd_rtc_core #(.DIV_COUNT(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .secByte(secByte), .minByte(minByte), .hourByte(hourByte), .dayByte(dayByte),
    .dateByte(dateByte), .monthByte(monthByte), .yearByte(yearByte)
  );

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      logic [55:0] e;
      logic [55:0] g;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      g = {secByte, minByte, hourByte, dayByte, dateByte, monthByte, yearByte};
      total++;
      if (g !== e) begin
        bad++;
        $display("FAIL %s: got s/m/h/d/D/M/Y=%h expected %h", t, g, e);
      end
    end
  end

  task automatic expectNow(input logic [7:0] s, m, h, d, dt, mo, y, input string tag);
    expQ.push_back({s, m, h, d, dt, mo, y});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [7:0] v);
    @(negedge clk);
    wrEn = 7'd1 << idx;
    wrData = v;
    @(posedge clk);
    #1;
    wrEn = '0;
  endtask

  task automatic setTime(input logic [7:0] h, m, s, d, dt, mo, y);
    wr(0, 8'h80);
    wr(1, m);
    wr(2, h);
    wr(3, d);
    wr(4, dt);
    wr(5, mo);
    wr(6, y);
    wr(0, s);
  endtask

  task automatic runSecs(input int n);
    repeat (DIV * n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!summaryDone) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summaryDone = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    expectNow(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset values");
    tickEn = 1'b1;

    // R2: spacing after a seconds write
    wr(0, 8'h10);
    repeat (DIV - 1) @(posedge clk); #1;
    expectNow(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 no tick before window");
    @(posedge clk); #1;
    expectNow(8'h11, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 tick at window");
    tickEn = 1'b0;
    repeat (20) @(posedge clk); #1;
    expectNow(8'h11, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 idle without enable");
    tickEn = 1'b1;
    repeat (2) @(posedge clk);
    wr(0, 8'h20);
    repeat (DIV - 1) @(posedge clk); #1;
    expectNow(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 divider restarted");
    @(posedge clk); #1;
    expectNow(8'h21, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 full second after write");

    // R4, R5, R7: midnight in 24-hour mode with day-of-week wrap
    setTime(8'h23, 8'h59, 8'h58, 8'h07, 8'h15, 8'h06, 8'h25);
    runSecs(1);
    expectNow(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h25, "R4 seconds to 59");
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h06, 8'h25, "R5 R7 midnight 24h");

    // R4, R5: hour carry without midnight
    setTime(8'h09, 8'h59, 8'h59, 8'h03, 8'h10, 8'h03, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h10, 8'h03, 8'h10, 8'h03, 8'h25, "R4 R5 hour carry 09 to 10");

    // R8: month lengths
    setTime(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h25, "R8 april 30 ends");
    setTime(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h05, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h04, 8'h31, 8'h05, 8'h25, "R8 may 30 goes to 31");

    // R9: february
    setTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23, "R9 common year feb 28");
    setTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h24, "R9 leap year feb 28");
    setTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h24, "R9 leap year feb 29");
    setTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, "R9 year 00 is leap");

    // R10: year ends
    setTime(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R10 year 99 wraps");
    setTime(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h29);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h30, "R10 year 29 to 30");

    // R6: 12-hour mode
    setTime(8'h51, 8'h59, 8'h59, 8'h02, 8'h10, 8'h01, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h72, 8'h02, 8'h10, 8'h01, 8'h25, "R6 11 AM to 12 PM");
    setTime(8'h72, 8'h59, 8'h59, 8'h02, 8'h10, 8'h01, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h61, 8'h02, 8'h10, 8'h01, 8'h25, "R6 12 PM to 01 PM");
    setTime(8'h71, 8'h59, 8'h59, 8'h02, 8'h10, 8'h01, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h52, 8'h03, 8'h11, 8'h01, 8'h25, "R6 R7 11 PM to 12 AM");
    setTime(8'h52, 8'h59, 8'h59, 8'h02, 8'h10, 8'h01, 8'h25);
    runSecs(1);
    expectNow(8'h00, 8'h00, 8'h41, 8'h02, 8'h10, 8'h01, 8'h25, "R6 12 AM to 01 AM");

    // R3: halt
    setTime(8'h08, 8'h30, 8'h05, 8'h04, 8'h12, 8'h07, 8'h25);
    wr(0, 8'h85);
    repeat (10 * DIV) @(posedge clk); #1;
    expectNow(8'h85, 8'h30, 8'h08, 8'h04, 8'h12, 8'h07, 8'h25, "R3 halted holds");
    wr(0, 8'h05);
    runSecs(1);
    expectNow(8'h06, 8'h30, 8'h08, 8'h04, 8'h12, 8'h07, 8'h25, "R3 resumes after clear");

    // R11: masking of unused bits
    wr(0, 8'h80);
    wr(1, 8'hA2);
    wr(2, 8'h95);
    wr(3, 8'hF3);
    wr(4, 8'hC7);
    wr(5, 8'hF2);
    expectNow(8'h80, 8'h22, 8'h15, 8'h03, 8'h07, 8'h12, 8'h25, "R11 unused bits dropped");

    summaryDone = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule